// File: doc/BRIEF.md
# Double-Buffered Column Line Memory

This block sits between a row of shared column converters and the digital output of a pixel array. Every converter serves a pair of neighbouring columns and produces two results per row: in the first conversion pass it delivers the code for the even column of its pair, in the second pass the code for the odd column. Each result is written into a front-end bank the moment it appears, so the converters never wait on the output side.

When the last conversion of a row is done, a single transfer pulse copies the whole front-end bank into a back-end bank in one clock. From the next cycle on, a stream engine sends the back-end bank out on sixteen parallel 10-bit lanes, one beat per clock. Meanwhile the converters are already filling the front-end bank with the following row. The column count is a parameter. It must be a power of two and at least 32, so a bench can run a small array.

Top module: `line_mem_dbuf`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0, `out_data` is all zeros, and both banks hold zero. A transfer issued straight after reset streams only zero codes.
- R2: A write with converter index `a` and phase 0 (first pass) stores `wr_code` into column 2a. With phase 1 (second pass) it stores into column 2a+1.
- R3: A clock edge with `xfer_req` high copies every front-end column into the back-end bank at once. In the cycle after that edge, `out_valid` is 1 and `out_beat` is 0.
- R4: On beat b, lane k (bits [10k+9:10k] of `out_data`) carries column 16b+k of the back-end bank.
- R5: A stream lasts NUM_COLS/16 consecutive cycles, with `out_beat` counting up by one from 0. `out_last` is high only on the final beat, and `out_valid` drops in the cycle after it.
- R6: Front-end writes made while a stream is running do not change any code of that stream.
- R7: A write in the same cycle as `xfer_req` lands in the front-end bank only. The transfer takes the bank contents from before that write.
- R8: A `xfer_req` during a stream reloads the back-end bank and restarts the stream at beat 0 with the new row.
- R9: `out_data` is all zeros whenever `out_valid` is 0.
- R10: A transfer does not clear the front-end bank. A column that is not rewritten keeps its previous code into the next row.
- R11: Without `xfer_req`, an idle stream engine stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Converter result valid this cycle |
| wr_adc | input | $clog2(NUM_COLS/2) | Index of the converter that produced the result |
| wr_phase | input | 1 | Conversion pass: 0 even column, 1 odd column |
| wr_code | input | 10 | Converted code |
| xfer_req | input | 1 | Row digitization complete: move row to back-end bank |
| out_valid | output | 1 | Output beat valid |
| out_beat | output | $clog2(NUM_COLS/16) | Index of the current beat |
| out_last | output | 1 | Final beat of the row |
| out_data | output | 160 | Sixteen 10-bit lanes, lane k in bits [10k+9:10k] |

## Verification
A wrong column decode or a wrong lane mapping puts a known code in the wrong lane or beat. This shows on the first stream after the faulty write. Leaked coupling between the banks shows up within the same stream as a code that changes between the transfer and its beat. A wrong beat counter or a missed restart shows in the very next cycle as a wrong `out_beat`, a missing `out_last`, or a stream of the wrong length.

// File: rtl/line_mem_pkg.sv
package line_mem_pkg;

    localparam int unsigned LM_CODE_W = 10;
    localparam int unsigned LM_LANES  = 16;
    localparam int unsigned LM_LANE_W = $clog2(LM_LANES);

    typedef enum logic {
        PASS_EVEN = 1'b0,
        PASS_ODD  = 1'b1
    } pass_e;

    function automatic int unsigned beats_for(int unsigned cols);
        return cols / LM_LANES;
    endfunction

    function automatic int unsigned safe_w(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lm_front_bank.sv
module lm_front_bank
    import line_mem_pkg::*;
#(
    parameter int unsigned NUM_COLS = 64,
    parameter int unsigned CODE_W   = LM_CODE_W,
    localparam int unsigned COL_W   = $clog2(NUM_COLS),
    localparam int unsigned ADC_W   = COL_W - 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [ADC_W-1:0]                 wr_adc,
    input  pass_e                            wr_phase,
    input  logic [CODE_W-1:0]                wr_code,
    output logic [NUM_COLS-1:0][CODE_W-1:0]  bank
);
    logic [COL_W-1:0] wr_col;
    assign wr_col = {wr_adc, wr_phase};

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (rst)
                bank[c] <= '0;
            else if (wr_en && (wr_col == COL_W'(c)))
                bank[c] <= wr_code;
        end
    end
endmodule

// File: rtl/lm_back_bank.sv
module lm_back_bank
    import line_mem_pkg::*;
#(
    parameter int unsigned NUM_COLS = 64,
    parameter int unsigned CODE_W   = LM_CODE_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             load,
    input  logic [NUM_COLS-1:0][CODE_W-1:0]  src,
    output logic [NUM_COLS-1:0][CODE_W-1:0]  bank
);
    always_ff @(posedge clk) begin
        if (rst)
            bank <= '0;
        else if (load)
            bank <= src;
    end
endmodule

// File: rtl/lm_stream_seq.sv
module lm_stream_seq
    import line_mem_pkg::*;
#(
    parameter int unsigned NUM_BEATS = 4,
    localparam int unsigned BEAT_W   = safe_w(NUM_BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic [BEAT_W-1:0] beat,
    output logic              last
);
    assign last = busy && (beat == BEAT_W'(NUM_BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            beat <= '0;
        end else if (start) begin
            busy <= 1'b1;
            beat <= '0;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
                beat <= '0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end
endmodule

// File: rtl/line_mem_dbuf.sv
module line_mem_dbuf
    import line_mem_pkg::*;
#(
    parameter int unsigned NUM_COLS  = 64,
    localparam int unsigned CODE_W   = LM_CODE_W,
    localparam int unsigned LANES    = LM_LANES,
    localparam int unsigned NUM_BEATS = beats_for(NUM_COLS),
    localparam int unsigned BEAT_W   = safe_w(NUM_BEATS),
    localparam int unsigned COL_W    = $clog2(NUM_COLS),
    localparam int unsigned ADC_W    = COL_W - 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADC_W-1:0]          wr_adc,
    input  logic                      wr_phase,
    input  logic [CODE_W-1:0]         wr_code,
    input  logic                      xfer_req,
    output logic                      out_valid,
    output logic [BEAT_W-1:0]         out_beat,
    output logic                      out_last,
    output logic [LANES*CODE_W-1:0]   out_data
);
    logic [NUM_COLS-1:0][CODE_W-1:0] front_q;
    logic [NUM_COLS-1:0][CODE_W-1:0] back_q;

    lm_front_bank #(.NUM_COLS(NUM_COLS), .CODE_W(CODE_W)) u_front (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_adc   (wr_adc),
        .wr_phase (pass_e'(wr_phase)),
        .wr_code  (wr_code),
        .bank     (front_q)
    );

    lm_back_bank #(.NUM_COLS(NUM_COLS), .CODE_W(CODE_W)) u_back (
        .clk  (clk),
        .rst  (rst),
        .load (xfer_req),
        .src  (front_q),
        .bank (back_q)
    );

    lm_stream_seq #(.NUM_BEATS(NUM_BEATS)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (xfer_req),
        .busy  (out_valid),
        .beat  (out_beat),
        .last  (out_last)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [COL_W-1:0] col_sel;
        assign col_sel = COL_W'({out_beat, LM_LANE_W'(k)});
        assign out_data[k*CODE_W +: CODE_W] = out_valid ? back_q[col_sel] : '0;
    end
endmodule

// File: rtl/lm_stream_checker.sv
module lm_stream_checker
    import line_mem_pkg::*;
#(
    parameter int unsigned NUM_COLS = 64,
    localparam int unsigned NUM_BEATS = beats_for(NUM_COLS),
    localparam int unsigned BEAT_W = safe_w(NUM_BEATS),
    localparam int unsigned DW = LM_LANES * LM_CODE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              xfer_req,
    input logic              out_valid,
    input logic [BEAT_W-1:0] out_beat,
    input logic              out_last,
    input logic [DW-1:0]     out_data
);
    assert_start_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
        xfer_req |=> (out_valid && out_beat == '0));

    assert_beat_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last && !xfer_req) |=> (out_valid && out_beat == $past(out_beat) + 1'b1));

    assert_end_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        (out_last && !xfer_req) |=> !out_valid);

    assert_last_in_stream_R5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));

    assert_no_self_start_R11: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !xfer_req) |=> !out_valid);
endmodule

bind line_mem_dbuf lm_stream_checker #(.NUM_COLS(NUM_COLS)) u_stream_chk (
    .clk       (clk),
    .rst       (rst),
    .xfer_req  (xfer_req),
    .out_valid (out_valid),
    .out_beat  (out_beat),
    .out_last  (out_last),
    .out_data  (out_data)
);

// File: tb/test_line_mem_dbuf.sv
`timescale 1ns/1ps
module test_line_mem_dbuf;
    localparam int COLS  = 64;
    localparam int LANES = 16;
    localparam int W     = 10;
    localparam int BEATS = COLS / LANES;
    localparam int NADC  = COLS / 2;

    logic clk = 1'b0;
    logic rst;
    logic wr_en, wr_phase, xfer_req;
    logic [4:0] wr_adc;
    logic [W-1:0] wr_code;
    logic out_valid, out_last;
    logic [1:0] out_beat;
    logic [LANES*W-1:0] out_data;

    int n_vec = 0;
    int n_bad = 0;
    logic [W-1:0] exp_front [COLS];
    logic [W-1:0] exp_back  [COLS];

    always #2.5 clk = ~clk;

    line_mem_dbuf #(.NUM_COLS(COLS)) i_line_mem_dbuf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_adc(wr_adc), .wr_phase(wr_phase),
        .wr_code(wr_code), .xfer_req(xfer_req), .out_valid(out_valid),
        .out_beat(out_beat), .out_last(out_last), .out_data(out_data)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [LANES*W-1:0] act, input logic [LANES*W-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] code_of(int col, int seed);
        return W'((col * 37 + seed * 113 + 5) & 10'h3FF);
    endfunction

    function automatic logic [LANES*W-1:0] exp_vec(int b);
        logic [LANES*W-1:0] v;
        for (int k = 0; k < LANES; k++) v[k*W +: W] = exp_back[b*LANES + k];
        return v;
    endfunction

    task automatic set_write(int adc, int ph, logic [W-1:0] code);
        wr_en = 1'b1; wr_adc = 5'(adc); wr_phase = ph[0]; wr_code = code;
        exp_front[2*adc + ph] = code;
    endtask

    task automatic do_write(int adc, int ph, logic [W-1:0] code);
        set_write(adc, ph, code);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic fill_row(int seed);
        for (int ph = 0; ph < 2; ph++)
            for (int a = 0; a < NADC; a++)
                do_write(a, ph, code_of(2*a + ph, seed));
    endtask

    task automatic pulse_xfer;
        xfer_req = 1'b1;
        for (int c = 0; c < COLS; c++) exp_back[c] = exp_front[c];
        tick();
        xfer_req = 1'b0;
    endtask

    // Stream check: lane mapping R4, length and flags R5; optional writes for R6
    task automatic check_stream(input string req, input bit wr_during, input int seed);
        for (int b = 0; b < BEATS; b++) begin
            chk(out_valid == 1'b1, req, "valid", {159'b0, out_valid}, 160'd1);
            chk(out_beat == 2'(b), req, "beat", {158'b0, out_beat}, 160'(b));
            chk(out_last == (b == BEATS - 1), req, "last", {159'b0, out_last}, 160'(b == BEATS - 1));
            chk(out_data == exp_vec(b), req, "data", out_data, exp_vec(b));
            if (wr_during) set_write(b, b % 2, code_of(b, seed));
            tick();
            wr_en = 1'b0;
        end
        chk(out_valid == 1'b0, req, "valid end", {159'b0, out_valid}, 160'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1; wr_en = 0; wr_adc = 0; wr_phase = 0; wr_code = 0; xfer_req = 0;
        for (int c = 0; c < COLS; c++) begin exp_front[c] = '0; exp_back[c] = '0; end
        repeat (3) tick();
        rst = 1'b0;
        chk(out_valid == 0 && out_last == 0, "R1", "flags", {158'b0, out_valid, out_last}, 160'd0);
        chk(out_data == '0, "R1", "data", out_data, '0);
        repeat (5) tick();
        chk(out_valid == 0, "R11", "idle", {159'b0, out_valid}, 160'd0);
        chk(out_data == '0, "R9", "idle data", out_data, '0);
        pulse_xfer();
        check_stream("R1", 1'b0, 0);
    endtask

    task automatic t_basic;
        fill_row(1);
        pulse_xfer();
        check_stream("R2", 1'b0, 0);
        chk(out_data == '0, "R9", "after stream", out_data, '0);
    endtask

    task automatic t_isolation;
        fill_row(2);
        pulse_xfer();
        check_stream("R6", 1'b1, 7);
        pulse_xfer();
        check_stream("R10", 1'b0, 0);
    endtask

    task automatic t_same_cycle;
        fill_row(3);
        xfer_req = 1'b1;
        for (int c = 0; c < COLS; c++) exp_back[c] = exp_front[c];
        set_write(0, 0, 10'h2A5);
        tick();
        xfer_req = 1'b0; wr_en = 1'b0;
        check_stream("R7", 1'b0, 0);
        pulse_xfer();
        check_stream("R7", 1'b0, 0);
    endtask

    task automatic t_restart;
        fill_row(4);
        pulse_xfer();
        do_write(0, 0, 10'h155);
        do_write(0, 1, 10'h0AA);
        chk(out_beat == 2'd2, "R8", "mid beat", {158'b0, out_beat}, 160'd2);
        pulse_xfer();
        check_stream("R8", 1'b0, 0);
        repeat (4) tick();
        chk(out_valid == 0, "R11", "stays idle", {159'b0, out_valid}, 160'd0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_isolation();
        t_same_cycle();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule